// File: doc/BRIEF.md
# Handshake Core Register Wrapper

This block puts a small compute core behind an AXI4-Lite slave port. Software sees eight 32-bit word registers. One register holds the core's start and reset controls. A read-only register reports whether the core is done, idle or ready. Three registers hold the operands a, b and c, and a read-only register returns the full result. The last two registers are plain scratch storage. The low byte of the last completed result drives an LED port.

The core uses a block-level handshake. When a start request is pending and the core is idle, it takes a copy of all three operands and leaves idle for a single cycle. In that cycle it raises done and ready together and the result becomes valid. It then returns to idle. The result it produces is its c operand. A short done pulse is easy to miss by polling, so the wrapper keeps a sticky done flag. That flag stays set until software writes the control register again.

Top module: `hs_core_axil`

## Requirements
- R1: After reset, every register reads zero except status, which reads 0x2 (idle only), and the LED port is zero.
- R2: A write is accepted in the cycle in which both address and data are valid, and is answered by one OKAY write response. A read returns its data with an OKAY response in the cycle after the address is accepted. Each response stays valid until it is accepted.
- R3: Registers 0, 2, 3, 4, 6 and 7 are writable, and each byte lane is updated only when its strobe bit is set. The register is selected by address bits [4:2].
- R4: Register 1 (status) and register 5 (result) are read-only, and writes to them change nothing.
- R5: Control register 0 uses bit 0 as start and bit 1 as core reset. A pending start is taken one cycle after the write, provided the core is idle and not held in reset. Start bit 0 clears itself when the core takes the request.
- R6: The core copies the c operand (register 4) when it takes a start. A later write to register 4 does not change that run's result.
- R7: One cycle after the start is taken, the run completes. Register 5 then returns the c copy in full, and the LED port shows its low 8 bits. Both hold until the next completion.
- R8: Status register 1 uses bit 0 for done, bit 1 for idle and bit 2 for ready. Idle is low and ready is high only during the single completion cycle. Done is set at completion and stays set until the next write to register 0.
- R9: While control bit 1 is set, the core stays idle, a pending start waits, and done, the result and the LED port are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| led | output | LED_W | Low bits of the last completed result |

## Verification
The bench rewrites c right after issuing a start. A core that copied its operand late would report the new value instead of the old one. It clears done by writing a register other than 0 and then by writing register 0. A flag that was not sticky, or that was cleared by the wrong write, shows up as a wrong status word. It holds the core in reset while start is set. A design that ran anyway, or that dropped the pending start, would light the LEDs or read back the wrong control word. It also sends partial strobes and writes to the read-only slots. Lanes that leaked through would change the readback.

// File: rtl/hs_core_axil.sv
module hs_core_axil #(
  parameter int AW    = 5,
  parameter int LED_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    s_awaddr,
  input  logic             s_awvalid,
  output logic             s_awready,
  input  logic [31:0]      s_wdata,
  input  logic [3:0]       s_wstrb,
  input  logic             s_wvalid,
  output logic             s_wready,
  output logic [1:0]       s_bresp,
  output logic             s_bvalid,
  input  logic             s_bready,
  input  logic [AW-1:0]    s_araddr,
  input  logic             s_arvalid,
  output logic             s_arready,
  output logic [31:0]      s_rdata,
  output logic [1:0]       s_rresp,
  output logic             s_rvalid,
  input  logic             s_rready,
  output logic [LED_W-1:0] led
);
  localparam int NREG = 8;
  localparam int IW   = $clog2(NREG);
  localparam int ST_IX  = 1;
  localparam int RES_IX = 5;
  localparam int C_IX   = 4;

  logic [31:0] regs [NREG];
  logic        bvalid_q, rvalid_q;
  logic [31:0] rdata_q;
  logic        busy, done_st;
  logic [31:0] lc, res;

  wire [IW-1:0] widx = s_awaddr[IW+1:2];
  wire [IW-1:0] ridx = s_araddr[IW+1:2];
  wire wr_fire = s_awvalid & s_wvalid & ~bvalid_q;
  wire rd_fire = s_arvalid & ~rvalid_q;
  wire wr_ctrl = wr_fire && widx == '0;
  wire crst    = regs[0][1];
  wire accept  = regs[0][0] & ~busy & ~crst;
  wire [31:0] status = {29'd0, busy, ~busy, done_st};

  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = 2'b00;
  assign s_arready = ~rvalid_q;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_rresp   = 2'b00;
  assign led       = res[LED_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (accept) regs[0][0] <= 1'b0;
      if (wr_fire && widx != IW'(ST_IX) && widx != IW'(RES_IX))
        for (int b = 0; b < 4; b++)
          if (s_wstrb[b]) regs[widx][8*b +: 8] <= s_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_fire) bvalid_q <= 1'b1;
      else if (s_bready) bvalid_q <= 1'b0;
      if (rd_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= (ridx == IW'(ST_IX))  ? status :
                    (ridx == IW'(RES_IX)) ? res : regs[ridx];
      end else if (s_rready) rvalid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || crst) begin
      busy    <= 1'b0;
      res     <= '0;
      done_st <= 1'b0;
      if (!rst_n) lc <= '0;
    end else if (busy) begin
      busy    <= 1'b0;
      res     <= lc;
      done_st <= 1'b1;
    end else begin
      if (wr_ctrl) done_st <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        lc   <= regs[C_IX];
      end
    end
  end

  a_r8_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  a_r6_operand_copied: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lc == $past(regs[C_IX]));
  a_r7_led_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !crst) |=> $stable(led));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_st && !wr_ctrl && !crst) |=> done_st);
  a_r9_reset_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    crst |=> (!busy && res == '0));
  a_r2_bvalid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);
  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

// File: tb/hs_core_axil_test.sv
`timescale 1ns/100ps
module hs_core_axil_test;
  logic clk = 0, rst_n = 0;
  logic [4:0]  awaddr = 0, araddr = 0;
  logic        awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic        awready, wready, bvalid, rvalid, arready;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [7:0]  led;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  hs_core_axil uut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
    .led(led));

  logic [31:0] mr [8];
  logic        mbusy, mdone;
  logic [31:0] mlc, mres, exp_rd;

  function automatic logic [31:0] mread(int i);
    if (i == 1) return {29'd0, mbusy, !mbusy, mdone};
    if (i == 5) return mres;
    return mr[i];
  endfunction

  always @(posedge clk) begin : model
    bit wr, rd, acc, crs;
    int wi, ri;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mr[i] = 0;
      mbusy = 0; mdone = 0; mlc = 0; mres = 0; exp_rd = 0;
    end else begin
      wr = awvalid && wvalid && awready; wi = int'(awaddr[4:2]);
      rd = arvalid && arready;           ri = int'(araddr[4:2]);
      if (rd) exp_rd = mread(ri);
      crs = mr[0][1];
      acc = mr[0][0] && !mbusy && !crs;
      if (crs) begin
        mres = 0; mdone = 0; mbusy = 0;
      end else if (mbusy) begin
        mres = mlc; mdone = 1; mbusy = 0;
      end else begin
        if (wr && wi == 0) mdone = 0;
        if (acc) begin mlc = mr[4]; mbusy = 1; mr[0][0] = 0; end
      end
      if (wr && wi != 1 && wi != 5)
        for (int b = 0; b < 4; b++)
          if (wstrb[b]) mr[wi][8*b +: 8] = wdata[8*b +: 8];
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) chk("R7 led", {24'd0, led}, {24'd0, mres[7:0]});

  task automatic wr(int idx, logic [31:0] d, logic [3:0] st, string tag);
    @(negedge clk);
    awaddr = 5'(idx * 4); wdata = d; wstrb = st; awvalid = 1; wvalid = 1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk({tag, " bvalid"}, {31'd0, bvalid}, 32'd1);
    chk({tag, " bresp"}, {30'd0, bresp}, 32'd0);
  endtask

  task automatic rd(int idx, string tag, output logic [31:0] v);
    @(negedge clk);
    araddr = 5'(idx * 4); arvalid = 1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 0;
    v = rdata;
    chk({tag, " rvalid"}, {31'd0, rvalid}, 32'd1);
    chk({tag, " rresp"}, {30'd0, rresp}, 32'd0);
    chk(tag, v, exp_rd);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] cs [4] = '{32'hA5C3_1E77, 32'h0000_0001, 32'hFFFF_FF80, 32'h1234_5600};
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      rd(i, "R1 reset", v);
      chk("R1 literal", v, (i == 1) ? 32'h2 : 32'h0);
    end
    chk("R1 led", {24'd0, led}, 0);

    wr(2, 32'h1111_2222, 4'hF, "R2");
    wr(3, 32'h3333_4444, 4'hF, "R2");
    wr(6, 32'hDEAD_BEEF, 4'hF, "R2");
    wr(7, 32'h0BAD_F00D, 4'hF, "R2");
    rd(2, "R2 readback", v); chk("R2 literal", v, 32'h1111_2222);
    rd(7, "R2 readback", v);

    wr(6, 32'h5566_7788, 4'b0101, "R3");
    rd(6, "R3 strobe", v); chk("R3 literal", v, 32'hDE66_BE88);
    wr(3, 32'hFFFF_FFFF, 4'b0000, "R3");
    rd(3, "R3 no strobe", v);

    wr(1, 32'hFFFF_FFFF, 4'hF, "R4");
    wr(5, 32'hFFFF_FFFF, 4'hF, "R4");
    rd(1, "R4 status", v); chk("R4 literal", v, 32'h2);
    rd(5, "R4 result", v); chk("R4 literal", v, 32'h0);

    foreach (cs[k]) begin
      wr(4, cs[k], 4'hF, "R7");
      wr(0, 32'h1, 4'hF, "R5");
      rd(1, "R8 status after start", v);
      idle(3);
      rd(0, "R5 self-clear", v); chk("R5 literal", v, 32'h0);
      rd(1, "R8 done", v);      chk("R8 literal", v, 32'h3);
      rd(5, "R7 result", v);    chk("R7 literal", v, cs[k]);
      chk("R7 led literal", {24'd0, led}, {24'd0, cs[k][7:0]});
    end

    wr(4, 32'h0000_00C1, 4'hF, "R6");
    wr(0, 32'h1, 4'hF, "R6");
    wr(4, 32'h0000_0042, 4'hF, "R6");
    idle(3);
    rd(5, "R6 copied operand", v); chk("R6 literal", v, 32'hC1);

    wr(2, 32'h7, 4'hF, "R8");
    rd(1, "R8 sticky", v); chk("R8 literal", v, 32'h3);
    wr(0, 32'h0, 4'hF, "R8");
    rd(1, "R8 cleared", v); chk("R8 literal", v, 32'h2);

    wr(0, 32'h3, 4'hF, "R9");
    idle(4);
    rd(0, "R9 start waits", v); chk("R9 literal", v, 32'h3);
    rd(1, "R9 idle", v);        chk("R9 literal", v, 32'h2);
    rd(5, "R9 result clear", v); chk("R9 literal", v, 32'h0);
    chk("R9 led", {24'd0, led}, 0);
    wr(0, 32'h1, 4'hF, "R9");
    idle(4);
    rd(5, "R9 run after release", v); chk("R9 literal", v, 32'h42);
    rd(1, "R9 done after release", v);

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule